// File: doc/BRIEF.md
# Audio Data Block Count Sequencer

This block decides, once per isochronous cycle of a transmit audio stream, how many audio data blocks go into the packet for that cycle. It also keeps the running data block counter that the packet header carries. A cycle strobe from the bus timing logic triggers each decision. The result appears one clock later, together with a one-clock valid pulse.

There are two pacing modes. In the non-blocking mode every cycle carries data. Rates with a whole number of samples per cycle use a fixed count. The three 44.1 kHz-family rates use a short repeating pattern that comes from a small phase counter. The pattern places its rounded-up packets as early as possible, so the running total never falls behind the ideal sample position. In the blocking mode a packet carries either one full timestamp interval of blocks or nothing at all. The timestamp value supplied for the cycle makes the choice, and the all-ones value marks an empty cycle.

The header counter can be reported in one of two ways. It can be the value at the start of the packet, before this packet's blocks are added. It can also be the value at the end of the packet, after they are added. Rate, mode and header form are captured while the stream is stopped and are held while it runs.

Top module: `dblk_pacer`

## Requirements
- R1: In non-blocking mode the integer rates give a fixed count per strobe: code 0 (32 kHz) gives 4, code 2 (48 kHz) gives 6, code 4 (96 kHz) gives 12 and code 6 (192 kHz) gives 24.
- R2: In non-blocking mode at code 1 (44.1 kHz) the count for phase p (0 to 79, wrapping to 0) is 5 + ((p mod 2) XOR (p = 0 or p >= 40)). This makes the running total after k strobes equal ceil(k * 44100 / 8000).
- R3: In non-blocking mode, code 3 (88.2 kHz) gives 11 + (p = 0) with the phase wrapping after 39. Code 5 (176.4 kHz) gives 22 + (p = 0) with the phase wrapping after 19.
- R4: While `run` is low, the phase and the data block counter are held at 0. Each stream therefore begins at phase 0 with a counter of 0.
- R5: In blocking mode the count is 8 for codes 0, 1 and 2, 16 for codes 3 and 4, and 32 for codes 5 and 6, provided `syt_in` is not 0xFFFF. The count is 0 when `syt_in` is 0xFFFF. The phase does not move in this mode.
- R6: The data block counter advances by the count of each packet, modulo 256.
- R7: With `end_mark` low, `dbc_out` shows the counter before this packet's advance. With `end_mark` high, it shows the counter after the advance.
- R8: A strobe taken while `run` is high gives `out_vld` high for exactly the next clock, with `blk_cnt` and `dbc_out` updated on that clock. With no strobe the outputs, the phase and the counter hold, and a strobe while `run` is low produces nothing.
- R9: `rate_sel`, `blocking` and `end_mark` are captured only while `run` is low. Changes while `run` is high have no effect until the next stop.
- R10: Rate code 7 is unused. It gives a count of 0 in both modes and leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Stream running; low = stopped, configuration captured |
| rate_sel | input | 3 | Sample rate code (0..6, 7 unused) |
| blocking | input | 1 | 1 = blocking pacing, 0 = non-blocking |
| end_mark | input | 1 | 1 = header counter after advance, 0 = before |
| cyc_stb | input | 1 | One pulse per isochronous cycle |
| syt_in | input | 16 | Timestamp for this cycle; 0xFFFF = no data |
| blk_cnt | output | 6 | Data blocks for this cycle's packet |
| dbc_out | output | 8 | Data block counter value for the header |
| out_vld | output | 1 | One-clock pulse: blk_cnt and dbc_out are new |

## Verification
Two events can fall on the same strobe: the phase wrapping back to 0, and the data block counter crossing 255. This is provoked by running each fractional rate for well over two full phase periods, so that the 8-bit counter wraps several times at differing phases. Each strobe is judged against a running total computed in the bench with ceiling arithmetic, taken modulo 256. A second collision is a change on the configuration inputs in the same cycle as a strobe while running. The bench judges this by checking that the count still follows the rate captured at start.

// File: rtl/dblk_pkg.sv
package dblk_pkg;

   typedef enum logic [2:0] {
      RATE_32K   = 3'd0,
      RATE_44K1  = 3'd1,
      RATE_48K   = 3'd2,
      RATE_88K2  = 3'd3,
      RATE_96K   = 3'd4,
      RATE_176K4 = 3'd5,
      RATE_192K  = 3'd6,
      RATE_NONE  = 3'd7
   } rate_e;

   typedef struct packed {
      rate_e rate;
      logic  blocking;
      logic  end_mark;
   } cfg_t;

   // rates from the 44.1 kHz family need the phase pattern
   function automatic logic is_frac(rate_e r);
      return (r == RATE_44K1) || (r == RATE_88K2) || (r == RATE_176K4);
   endfunction

   // number of phase steps before the pattern repeats
   function automatic logic [6:0] phase_limit(rate_e r);
      case (r)
         RATE_44K1:  return 7'd80;
         RATE_88K2:  return 7'd40;
         RATE_176K4: return 7'd20;
         default:    return 7'd1;
      endcase
   endfunction

   function automatic logic [5:0] fixed_count(rate_e r);
      case (r)
         RATE_32K:  return 6'd4;
         RATE_48K:  return 6'd6;
         RATE_96K:  return 6'd12;
         RATE_192K: return 6'd24;
         default:   return 6'd0;
      endcase
   endfunction

   function automatic logic [5:0] block_interval(rate_e r);
      case (r)
         RATE_32K, RATE_44K1, RATE_48K: return 6'd8;
         RATE_88K2, RATE_96K:           return 6'd16;
         RATE_176K4, RATE_192K:         return 6'd32;
         default:                       return 6'd0;
      endcase
   endfunction

endpackage

// File: rtl/dblk_cfg_hold.sv
module dblk_cfg_hold
   import dblk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] rate_sel,
   input  logic       blocking,
   input  logic       end_mark,
   output cfg_t       cfg
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '{rate: RATE_32K, blocking: 1'b0, end_mark: 1'b0};
      end else if (!run) begin
         cfg <= '{rate: rate_e'(rate_sel), blocking: blocking, end_mark: end_mark};
      end
   end

endmodule

// File: rtl/dblk_phase.sv
module dblk_phase #(
   parameter int PH_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            adv,
   input  logic [PH_W-1:0] limit,
   output logic [PH_W-1:0] phase
);

   logic [PH_W-1:0] inc;

   assign inc = phase + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (clr) begin
         phase <= '0;
      end else if (adv) begin
         phase <= (inc >= limit) ? '0 : inc;
      end
   end

endmodule

// File: rtl/dblk_count_sel.sv
module dblk_count_sel
   import dblk_pkg::*;
#(
   parameter int          BLK_W     = 6,
   parameter int          PH_W      = 7,
   parameter int          SYT_W     = 16,
   parameter logic [15:0] SYT_EMPTY = 16'hFFFF
) (
   input  cfg_t             cfg,
   input  logic [PH_W-1:0]  phase,
   input  logic [SYT_W-1:0] syt_in,
   output logic [BLK_W-1:0] cnt
);

   localparam logic [PH_W-1:0] HALF44 = PH_W'(40);

   logic       ph_zero;
   logic [5:0] frac_cnt;
   logic [5:0] raw;

   assign ph_zero = (phase == '0);

   always_comb begin
      case (cfg.rate)
         RATE_44K1:  frac_cnt = 6'd5 + {5'd0, phase[0] ^ (ph_zero | (phase >= HALF44))};
         RATE_88K2:  frac_cnt = 6'd11 + {5'd0, ph_zero};
         RATE_176K4: frac_cnt = 6'd22 + {5'd0, ph_zero};
         default:    frac_cnt = 6'd0;
      endcase
   end

   always_comb begin
      if (cfg.blocking) begin
         raw = (syt_in == SYT_W'(SYT_EMPTY)) ? 6'd0 : block_interval(cfg.rate);
      end else if (is_frac(cfg.rate)) begin
         raw = frac_cnt;
      end else begin
         raw = fixed_count(cfg.rate);
      end
   end

   assign cnt = BLK_W'(raw);

endmodule

// File: rtl/dblk_acc.sv
module dblk_acc #(
   parameter int DBC_W = 8,
   parameter int BLK_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [BLK_W-1:0] add,
   output logic [DBC_W-1:0] ctr,
   output logic [DBC_W-1:0] ctr_next
);

   generate
      if (DBC_W > BLK_W) begin : g_wide
         assign ctr_next = ctr + {{(DBC_W-BLK_W){1'b0}}, add};
      end else begin : g_narrow
         assign ctr_next = ctr + add[DBC_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctr <= '0;
      end else if (clr) begin
         ctr <= '0;
      end else if (adv) begin
         ctr <= ctr_next;
      end
   end

endmodule

// File: rtl/dblk_pacer.sv
module dblk_pacer
   import dblk_pkg::*;
#(
   parameter int          BLK_W     = 6,
   parameter int          DBC_W     = 8,
   parameter int          PH_W      = 7,
   parameter int          SYT_W     = 16,
   parameter logic [15:0] SYT_EMPTY = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [2:0]       rate_sel,
   input  logic             blocking,
   input  logic             end_mark,
   input  logic             cyc_stb,
   input  logic [SYT_W-1:0] syt_in,
   output logic [BLK_W-1:0] blk_cnt,
   output logic [DBC_W-1:0] dbc_out,
   output logic             out_vld
);

   generate
      if (BLK_W < 6) begin : g_bad_blk
         $error("BLK_W must hold a count of 32");
      end
      if (PH_W < 7) begin : g_bad_ph
         $error("PH_W must hold a phase of 79");
      end
      if (DBC_W < 1) begin : g_bad_dbc
         $error("DBC_W must be positive");
      end
   endgenerate

   cfg_t             cfg_q;
   logic [PH_W-1:0]  phase_q;
   logic [BLK_W-1:0] cnt;
   logic [DBC_W-1:0] ctr_q;
   logic [DBC_W-1:0] ctr_nx;
   logic             take;
   logic             ph_adv;

   assign take   = run & cyc_stb;
   assign ph_adv = take & ~cfg_q.blocking & is_frac(cfg_q.rate);

   dblk_cfg_hold u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .rate_sel (rate_sel),
      .blocking (blocking),
      .end_mark (end_mark),
      .cfg      (cfg_q)
   );

   dblk_phase #(.PH_W(PH_W)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (~run),
      .adv   (ph_adv),
      .limit (PH_W'(phase_limit(cfg_q.rate))),
      .phase (phase_q)
   );

   dblk_count_sel #(
      .BLK_W     (BLK_W),
      .PH_W      (PH_W),
      .SYT_W     (SYT_W),
      .SYT_EMPTY (SYT_EMPTY)
   ) u_sel (
      .cfg    (cfg_q),
      .phase  (phase_q),
      .syt_in (syt_in),
      .cnt    (cnt)
   );

   dblk_acc #(.DBC_W(DBC_W), .BLK_W(BLK_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (~run),
      .adv      (take),
      .add      (cnt),
      .ctr      (ctr_q),
      .ctr_next (ctr_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_cnt <= '0;
         dbc_out <= '0;
         out_vld <= 1'b0;
      end else begin
         out_vld <= take;
         if (take) begin
            blk_cnt <= cnt;
            dbc_out <= cfg_q.end_mark ? ctr_nx : ctr_q;
         end
      end
   end

endmodule

// File: rtl/dblk_pacer_chk.sv
module dblk_pacer_chk #(
   parameter int          BLK_W     = 6,
   parameter int          DBC_W     = 8,
   parameter int          PH_W      = 7,
   parameter int          SYT_W     = 16,
   parameter logic [15:0] SYT_EMPTY = 16'hFFFF
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             cyc_stb,
   input logic [SYT_W-1:0] syt_in,
   input logic [BLK_W-1:0] blk_cnt,
   input logic [DBC_W-1:0] dbc_out,
   input logic             out_vld,
   input logic [DBC_W-1:0] ctr,
   input logic [PH_W-1:0]  phase,
   input logic [2:0]       cfg_rate,
   input logic             cfg_blk,
   input logic             cfg_end
);

   AST_FIXED_48K: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld && !cfg_blk && cfg_rate == 3'd2 |-> blk_cnt == BLK_W'(6)); // R1

   AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      phase < PH_W'(80)); // R2

   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ctr == '0 && phase == '0); // R4

   AST_EMPTY_PKT: assert property (@(posedge clk) disable iff (!rst_n)
      run && cyc_stb && cfg_blk && syt_in == SYT_W'(SYT_EMPTY) |=> blk_cnt == '0); // R5

   AST_CTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      run && cyc_stb |=> ctr == DBC_W'($past(ctr) + DBC_W'(blk_cnt))); // R6

   AST_HDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> dbc_out == (cfg_end ? ctr : DBC_W'(ctr - DBC_W'(blk_cnt)))); // R7

   AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !(run && cyc_stb) |=> !out_vld); // R8

   AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      run && !cyc_stb |=> $stable(ctr) && $stable(phase)); // R8

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> $stable(cfg_rate) && $stable(cfg_blk) && $stable(cfg_end)); // R9

endmodule

bind dblk_pacer dblk_pacer_chk #(
   .BLK_W     (BLK_W),
   .DBC_W     (DBC_W),
   .PH_W      (PH_W),
   .SYT_W     (SYT_W),
   .SYT_EMPTY (SYT_EMPTY)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .cyc_stb  (cyc_stb),
   .syt_in   (syt_in),
   .blk_cnt  (blk_cnt),
   .dbc_out  (dbc_out),
   .out_vld  (out_vld),
   .ctr      (ctr_q),
   .phase    (phase_q),
   .cfg_rate (cfg_q.rate),
   .cfg_blk  (cfg_q.blocking),
   .cfg_end  (cfg_q.end_mark)
);

// File: tb/sim_dblk_pacer.sv
`timescale 1ns/1ps
module sim_dblk_pacer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [2:0]  rate_sel = 3'd0;
   logic        blocking = 1'b0;
   logic        end_mark = 1'b0;
   logic        cyc_stb = 1'b0;
   logic [15:0] syt_in = 16'h0;
   logic [5:0]  blk_cnt;
   logic [7:0]  dbc_out;
   logic        out_vld;

   int n_run  = 0;
   int n_fail = 0;
   int k      = 0;
   int exp_ctr = 0;
   int cur_rate = 0;
   bit cur_blk = 0;
   bit cur_end = 0;

   always #2.5 clk = ~clk;

   dblk_pacer u0 (
      .clk(clk), .rst_n(rst_n), .run(run), .rate_sel(rate_sel),
      .blocking(blocking), .end_mark(end_mark), .cyc_stb(cyc_stb),
      .syt_in(syt_in), .blk_cnt(blk_cnt), .dbc_out(dbc_out), .out_vld(out_vld)
   );

   task automatic check(bit ok, string req, int act, int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int rate_hz(int r);
      case (r)
         0: return 32000;  1: return 44100;  2: return 48000;
         3: return 88200;  4: return 96000;  5: return 176400;
         6: return 192000; default: return 0;
      endcase
   endfunction

   function automatic int ceil_div(int a, int b);
      return (a + b - 1) / b;
   endfunction

   function automatic int interval(int r);
      if (r <= 2) return 8;
      if (r <= 4) return 16;
      if (r <= 6) return 32;
      return 0;
   endfunction

   function automatic int expect_cnt(int r, bit b, int idx, logic [15:0] syt);
      if (b) return (syt == 16'hFFFF) ? 0 : interval(r);
      return ceil_div((idx + 1) * rate_hz(r), 8000) - ceil_div(idx * rate_hz(r), 8000);
   endfunction

   task automatic start_stream(int r, bit b, bit e);
      @(negedge clk);
      run = 1'b0; rate_sel = 3'(r); blocking = b; end_mark = e;
      @(negedge clk);
      run = 1'b1;
      cur_rate = r; cur_blk = b; cur_end = e; k = 0; exp_ctr = 0;
   endtask

   task automatic strobe(logic [15:0] syt, string req);
      int c;
      int hdr;
      cyc_stb = 1'b1; syt_in = syt;
      @(negedge clk);
      cyc_stb = 1'b0;
      c = expect_cnt(cur_rate, cur_blk, k, syt);
      hdr = cur_end ? ((exp_ctr + c) % 256) : exp_ctr;
      exp_ctr = (exp_ctr + c) % 256;
      check(out_vld == 1'b1, {req, " R8 vld"}, int'(out_vld), 1);
      check(int'(blk_cnt) == c, {req, " count"}, int'(blk_cnt), c);
      check(int'(dbc_out) == hdr, {req, " R6/R7 dbc"}, int'(dbc_out), hdr);
      k++;
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      check(out_vld == 1'b0, "R8 reset vld", int'(out_vld), 0);
      check(blk_cnt == 6'd0, "R4 reset count", int'(blk_cnt), 0);
      check(dbc_out == 8'd0, "R4 reset dbc", int'(dbc_out), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // non-blocking sweep, header before advance: R1 R2 R3 R10
      for (int r = 0; r < 8; r++) begin
         start_stream(r, 1'b0, 1'b0);
         for (int i = 0; i < 170; i++) begin
            case (r)
               0, 2, 4, 6: strobe(16'h0123, "R1");
               1:          strobe(16'h0123, "R2");
               3, 5:       strobe(16'h0123, "R3");
               default:    strobe(16'h0123, "R10");
            endcase
         end
      end

      // header after advance: R7, phase wrap with counter wrap
      for (int r = 1; r <= 5; r += 2) begin
         start_stream(r, 1'b0, 1'b1);
         for (int i = 0; i < 130; i++) strobe(16'h0042, "R7");
      end

      // blocking mode, every third cycle empty: R5
      for (int r = 0; r < 8; r++) begin
         start_stream(r, 1'b1, r[0]);
         for (int i = 0; i < 30; i++)
            strobe((i % 3 == 2) ? 16'hFFFF : 16'(i * 97), r == 7 ? "R10" : "R5");
      end

      // restart mid-pattern: R4
      start_stream(1, 1'b0, 1'b0);
      for (int i = 0; i < 37; i++) strobe(16'h0, "R2");
      start_stream(1, 1'b0, 1'b0);
      strobe(16'h0, "R4 restart");
      strobe(16'h0, "R4 restart");

      // strobe gaps hold state: R8
      start_stream(3, 1'b0, 1'b0);
      for (int i = 0; i < 45; i++) begin
         strobe(16'h0, "R8 gap");
         for (int g = 0; g < (i % 4); g++) begin
            logic [5:0] held;
            held = blk_cnt;
            @(negedge clk);
            check(out_vld == 1'b0, "R8 no strobe vld", int'(out_vld), 0);
            check(blk_cnt == held, "R8 no strobe hold", int'(blk_cnt), int'(held));
         end
      end

      // strobe while stopped: R8
      @(negedge clk);
      run = 1'b0; cyc_stb = 1'b1;
      @(negedge clk);
      cyc_stb = 1'b0;
      check(out_vld == 1'b0, "R8 stopped strobe", int'(out_vld), 0);

      // configuration changes while running are ignored: R9
      start_stream(2, 1'b0, 1'b0);
      for (int i = 0; i < 20; i++) begin
         rate_sel = 3'(i % 8); blocking = i[0]; end_mark = i[1];
         strobe(16'hFFFF, "R9 frozen cfg");
      end

      @(negedge clk);
      run = 1'b0;
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule